// File: doc/BRIEF.md
# Multi-Rate Audio Clock Generator

This block derives the three clocks of a stereo serial audio port from one fast reference clock. The reference runs at 2048 times the normal-speed sample rate. The generated clocks are a master clock, a bit clock and a frame clock. A two-bit speed code selects normal, double or quad sample rate from that same reference. A master/slave select decides whether the block drives the bit and frame clocks or leaves them to another device.

Every output is a tap of one free-running frame counter, so the edges of all outputs stay aligned with one another. Speed and master/slave changes are held back until the current frame ends. The counter then starts again from zero, so no output ever produces a shortened pulse. In slave mode the output enables drop and all generated clocks are held low.

Top module: `acg_clkgen`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk_ref`, the counter clears and every clock output and output enable is low on the next cycle.
- R2: At normal speed in master mode, `mclk_o` has a period of 8 reference cycles (256 Fs) with 50% duty.
- R3: At double and quad speed in master mode, `mclk_o` has a period of 4 reference cycles (256 Fs at double speed, 128 Fs at quad speed).
- R4: In master mode, `bclk_o` has a period of 32, 16 or 8 reference cycles at normal, double or quad speed (always 64 Fs), with 50% duty.
- R5: In master mode, `lrclk_o` has a period of 2048, 1024 or 512 reference cycles. It is low for the first half of each frame (left channel) and high for the second half (right channel).
- R6: Every transition of `lrclk_o` coincides with a falling edge of `bclk_o`.
- R7: In slave mode, `bclk_oe` and `lrclk_oe` are low and `mclk_o`, `bclk_o` and `lrclk_o` are held low. In master mode both enables are high.
- R8: A new speed code or master/slave select takes effect only at the end of the frame in progress. The next frame starts with every output low and at full length.
- R9: Speed code encoding: 2'b00 normal, 2'b01 double, 2'b10 quad. The code 2'b11 behaves exactly as normal.
- R10: After reset release, or after any mode change, all outputs start low together, one cycle after the counter starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock, 2048 times the normal sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spd_code | input | 2 | Requested speed: 00 normal, 01 double, 10 quad, 11 normal |
| master_en | input | 1 | 1 = generate port clocks, 0 = external master |
| mclk_o | output | 1 | Master clock output, low in slave mode |
| bclk_o | output | 1 | Bit clock output value |
| bclk_oe | output | 1 | Output enable for the bit clock pad |
| lrclk_o | output | 1 | Frame clock output value |
| lrclk_oe | output | 1 | Output enable for the frame clock pad |

## Verification
The bench changes the speed in the middle of a frame and checks that the old rate continues to the end of that frame. A design that switched at once would cut the frame clock short and break the left/right alignment. It covers the move to quad speed, where the master clock stays at divide-by-4 while the bit clock halves. A design that kept a single master-clock ratio across all modes would run the master clock at the wrong rate there. It also runs the reserved speed code, a master-to-slave-and-back round trip in which any leaked edge on a disabled clock is caught, and a reset issued while the clocks are running. Every frame-clock edge is also checked against the bit clock, which exposes a frame clock taken from the wrong counter bit.

// File: rtl/acg_pkg.sv
// Package: shared types and helpers for the audio clock generator.
// Assumes the speed code is two bits wide and the reserved value maps to normal.
package acg_pkg;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_RSVD   = 2'd3
    } spd_e;

    typedef struct packed {
        spd_e spd;
        logic master;
    } cfg_t;

    // Map the raw pin code to a legal speed (reserved folds to normal, R9).
    function automatic spd_e decode_spd(input logic [1:0] code);
        case (code)
            2'd1:    return SPD_DOUBLE;
            2'd2:    return SPD_QUAD;
            default: return SPD_NORMAL;
        endcase
    endfunction

    // Number of halvings of the frame length for a given speed.
    function automatic int unsigned rate_shift(input spd_e s);
        case (s)
            SPD_DOUBLE: return 1;
            SPD_QUAD:   return 2;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/acg_mode_ctrl.sv
// Module: holds the active speed / master configuration.
// Assumes frame_end pulses for one cycle on the last count of each frame;
// requests are sampled only then, so a change lands on a frame boundary.
module acg_mode_ctrl
    import acg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] spd_code,
    input  logic       master_req,
    input  logic       frame_end,
    output cfg_t       cfg_q
);

    cfg_t cfg_req;

    // Decode the requested configuration from the pins.
    always_comb begin
        cfg_req.spd    = decode_spd(spd_code);
        cfg_req.master = master_req;
    end

    // Load during reset, otherwise adopt the request only at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_req;
        end else if (frame_end) begin
            cfg_q <= cfg_req;
        end
    end

endmodule

// File: rtl/acg_divider.sv
// Module: the single frame counter every output clock is tapped from.
// Assumes the normal-speed frame spans 2**CNT_W reference cycles; faster
// speeds shorten the frame by powers of two.
module acg_divider
    import acg_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    output logic [CNT_W-1:0] cnt_q,
    output logic             frame_end
);

    localparam logic [CNT_W-1:0] FULL_LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] frame_last;

    // Last count of the frame for the active speed.
    always_comb begin
        frame_last = FULL_LAST >> rate_shift(cfg.spd);
        frame_end  = (cnt_q == frame_last);
    end

    // Count up and wrap to zero at the end of every frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (frame_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: the counter never leaves the frame of the active speed
    p_cnt_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (FULL_LAST >> rate_shift(cfg.spd)));

    // R8: configuration only moves when the counter has just restarted
    p_cfg_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> (cnt_q == '0));

endmodule

// File: rtl/acg_tap_mux.sv
// Module: selects counter bits for each clock and registers the outputs.
// Assumes the counter restarts at zero each frame, so every tap begins low.
// Slave mode forces all values and enables low.
module acg_tap_mux
    import acg_pkg::*;
#(
    parameter int CNT_W          = 11,
    parameter int BCLK_LOG2      = 6,
    parameter int MCLK_NORM_LOG2 = 8,
    parameter int MCLK_QUAD_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] cnt,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             lrclk_o,
    output logic             oe_o
);

    localparam int LR_TOP = CNT_W - 1;
    localparam int IDX_W  = $clog2(CNT_W);

    logic [IDX_W-1:0] lr_idx, bclk_idx, mclk_idx;
    logic             mclk_d, bclk_d, lrclk_d;

    // Pick the tap index for each clock from the active speed.
    always_comb begin
        lr_idx   = IDX_W'(LR_TOP - int'(rate_shift(cfg.spd)));
        bclk_idx = IDX_W'(int'(lr_idx) - BCLK_LOG2);
        if (cfg.spd == SPD_QUAD) begin
            mclk_idx = IDX_W'(int'(lr_idx) - MCLK_QUAD_LOG2);
        end else begin
            mclk_idx = IDX_W'(int'(lr_idx) - MCLK_NORM_LOG2);
        end
        mclk_d  = cfg.master & cnt[mclk_idx];
        bclk_d  = cfg.master & cnt[bclk_idx];
        lrclk_d = cfg.master & cnt[lr_idx];
    end

    // Register the gated taps so the pads see clean, aligned edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mclk_o  <= 1'b0;
            bclk_o  <= 1'b0;
            lrclk_o <= 1'b0;
            oe_o    <= 1'b0;
        end else begin
            mclk_o  <= mclk_d;
            bclk_o  <= bclk_d;
            lrclk_o <= lrclk_d;
            oe_o    <= cfg.master;
        end
    end

    // R1: the cycle after a reset edge shows every output low
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!mclk_o && !bclk_o && !lrclk_o && !oe_o));

    // R6: frame clock moves only together with a falling bit clock
    p_lr_on_bclk_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk_o) |-> $fell(bclk_o));

    // R7: with the pad disabled no clock value is presented
    p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> (!mclk_o && !bclk_o && !lrclk_o));

endmodule

// File: rtl/acg_clkgen.sv
// Module: top of the multi-rate audio clock generator.
// Assumes clk_ref is 2048 times the normal sample rate; the mode inputs may
// change at any time and are applied at the next frame boundary.
module acg_clkgen
    import acg_pkg::*;
#(
    parameter int CNT_W          = 11,
    parameter int BCLK_LOG2      = 6,
    parameter int MCLK_NORM_LOG2 = 8,
    parameter int MCLK_QUAD_LOG2 = 7
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic [1:0] spd_code,
    input  logic       master_en,
    output logic       mclk_o,
    output logic       bclk_o,
    output logic       bclk_oe,
    output logic       lrclk_o,
    output logic       lrclk_oe
);

    cfg_t             cfg;
    logic [CNT_W-1:0] cnt;
    logic             frame_end;
    logic             oe;

    acg_mode_ctrl u_mode (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .spd_code   (spd_code),
        .master_req (master_en),
        .frame_end  (frame_end),
        .cfg_q      (cfg)
    );

    acg_divider #(.CNT_W(CNT_W)) u_div (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .cnt_q     (cnt),
        .frame_end (frame_end)
    );

    acg_tap_mux #(
        .CNT_W          (CNT_W),
        .BCLK_LOG2      (BCLK_LOG2),
        .MCLK_NORM_LOG2 (MCLK_NORM_LOG2),
        .MCLK_QUAD_LOG2 (MCLK_QUAD_LOG2)
    ) u_taps (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .cnt     (cnt),
        .mclk_o  (mclk_o),
        .bclk_o  (bclk_o),
        .lrclk_o (lrclk_o),
        .oe_o    (oe)
    );

    // Both port clocks share one direction control.
    always_comb begin
        bclk_oe  = oe;
        lrclk_oe = oe;
    end

endmodule

// File: tb/test_acg_clkgen.sv
// Scoreboard bench: the driver steps a cycle model and queues the expected
// outputs; the monitor pops them at the falling edge and compares.
module test_acg_clkgen;

    localparam int CLK_PERIOD = 10;

    logic       clk_ref = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] spd_code = 2'd0;
    logic       master_en = 1'b1;
    logic       mclk_o, bclk_o, bclk_oe, lrclk_o, lrclk_oe;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic  mclk;
        logic  bclk;
        logic  lr;
        logic  oe;
        string tag;
    } exp_t;

    exp_t q[$];

    int   m_p = 0;
    int   m_sh = 0;
    logic m_master = 1'b0;
    logic m_rsvd = 1'b0;

    acg_clkgen i_acg_clkgen (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .spd_code (spd_code),
        .master_en(master_en),
        .mclk_o   (mclk_o),
        .bclk_o   (bclk_o),
        .bclk_oe  (bclk_oe),
        .lrclk_o  (lrclk_o),
        .lrclk_oe (lrclk_oe)
    );

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    function automatic int shift_of(input logic [1:0] c);
        if (c == 2'd1) return 1;
        if (c == 2'd2) return 2;
        return 0;
    endfunction

    // Driver: advance one reference cycle and queue what the outputs must show.
    task automatic step();
        exp_t e;
        int   fdiv, bdiv, mdiv;
        @(posedge clk_ref);
        if (!rst_n) begin
            e.mclk = 1'b0; e.bclk = 1'b0; e.lr = 1'b0; e.oe = 1'b0;
            e.tag = "R1";
            m_p = 0;
            m_sh = shift_of(spd_code);
            m_master = master_en;
            m_rsvd = (spd_code == 2'd3);
        end else begin
            fdiv = 2048 >> m_sh;
            bdiv = 32 >> m_sh;
            mdiv = (m_sh == 0) ? 8 : 4;
            e.mclk = m_master && ((m_p % mdiv) >= mdiv/2);
            e.bclk = m_master && ((m_p % bdiv) >= bdiv/2);
            e.lr   = m_master && ((m_p % fdiv) >= fdiv/2);
            e.oe   = m_master;
            if (!m_master)      e.tag = "R7 R10";
            else if (m_sh == 0) e.tag = m_rsvd ? "R9 R2 R4 R5" : "R2 R4 R5";
            else                e.tag = "R3 R4 R5";
            if (shift_of(spd_code) != m_sh || master_en != m_master)
                e.tag = {e.tag, " R8"};
            if (m_p == fdiv - 1) begin
                m_p = 0;
                m_sh = shift_of(spd_code);
                m_master = master_en;
                m_rsvd = (spd_code == 2'd3);
            end else begin
                m_p++;
            end
        end
        q.push_back(e);
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    task automatic set_cfg(input logic [1:0] code, input logic m);
        @(negedge clk_ref);
        spd_code = code;
        master_en = m;
    endtask

    logic prev_b = 1'b0;
    logic prev_lr = 1'b0;

    // Monitor: compare the queued expectation with the ports between edges.
    always @(negedge clk_ref) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (mclk_o !== e.mclk || bclk_o !== e.bclk || lrclk_o !== e.lr ||
                bclk_oe !== e.oe || lrclk_oe !== e.oe) begin
                errors++;
                $display("FAIL %s t=%0t mclk/bclk/lr/bclk_oe/lrclk_oe act=%b%b%b%b%b exp=%b%b%b%b%b",
                         e.tag, $time, mclk_o, bclk_o, lrclk_o, bclk_oe, lrclk_oe,
                         e.mclk, e.bclk, e.lr, e.oe, e.oe);
            end
        end
        // R6: a frame clock edge must come with a falling bit clock
        if (rst_n && lrclk_o !== prev_lr) begin
            checks++;
            if (!(prev_b === 1'b1 && bclk_o === 1'b0)) begin
                errors++;
                $display("FAIL R6 t=%0t bclk prev/now act=%b%b exp=10", $time, prev_b, bclk_o);
            end
        end
        prev_b = bclk_o;
        prev_lr = lrclk_o;
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        run(4);                        // R1 reset state
        @(negedge clk_ref); rst_n = 1'b1;
        run(4096);                     // R2 R4 R5 normal, two frames
        run(300);
        set_cfg(2'd1, 1'b1);           // R8 mid-frame request for double speed
        run(3000);                     // R3 double
        run(100);
        set_cfg(2'd2, 1'b1);           // R3 quad: mclk stays /4, bclk /8
        run(2000);
        set_cfg(2'd3, 1'b1);           // R9 reserved code
        run(4500);
        set_cfg(2'd0, 1'b0);           // R7 slave
        run(4500);
        set_cfg(2'd2, 1'b1);           // R8 R10 back to master at quad
        run(2000);
        @(negedge clk_ref); rst_n = 1'b0;  // R1 reset while running
        run(3);
        @(negedge clk_ref); rst_n = 1'b1;
        run(1200);
        @(negedge clk_ref);
        @(negedge clk_ref);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule